// File: doc/BRIEF.md
# Paired Data-Ready Router

This block sits between six conversion channels and the host-facing data-ready pins. The channels are grouped into three pairs: channels 0/1, 2/3 and 4/5. Each channel signals a finished conversion with a one-cycle strobe. The block turns these strobes into one active-low data-ready pin per pair. A two-bit selector per pair chooses which strobes reach the pin. In the lag-select setting, a signed phase code per pair decides which channel of the pair finishes last.

A global link switch joins all six channels into one event. That event fires once every channel has completed since the previous event. It is blanked when any channel is held in reset or shutdown. An optional settling gate hides the first conversions after a channel starts.

The block also keeps one ready flag per channel for a status read. It issues per-channel capture enables for the result words. It adds a second capture stage tied to the start of a host read, and holds back any capture that arrives while that read is in progress.

Top module: `drdy_route`

## Requirements
- R1: With link off and a pair's selector (`pair_sel[2p+1:2p]`) at 00, the pin follows only the lagging channel of that pair. The even channel 2p lags when the phase code `pair_phase[8p+7:8p]`, read as signed, is above zero. Otherwise the odd channel 2p+1 lags.
- R2: Selector 01 forwards only the even channel's strobe and selector 10 forwards only the odd channel's strobe. A strobe from the other channel leaves the pin high.
- R3: Selector 11 forwards the strobes of both channels. Two strobes in the same cycle give a single pulse.
- R4: In lag-select, if one channel of a pair is held (`ch_hold` bit set), the other channel's strobe is forwarded. A held channel has no effect on the other pairs.
- R5: With `settle_en` high, a channel's first three strobes after reset, or after its hold is released, produce no event. The fourth and later strobes do. With `settle_en` low, every strobe counts.
- R6: With `link_en` high, the selectors are ignored. All three pins pulse together one cycle after the strobe that completes the set of six channels since the last linked event.
- R7: With `link_en` high and any channel held, no pin pulses and the ready flags do not change.
- R8: `stat_n` resets to all ones. A channel's bit clears on its own event; in link mode, all bits clear on the linked event. `stat_rd` sets all bits to one. An event in the same cycle as `stat_rd` still clears its bit.
- R9: `rdy_oe` is high whenever a pin pulses. When `idle_drive` is high, `rdy_oe` is high on every pin. When `idle_drive` is low, an idle pin has `rdy_oe` low.
- R10: `cap_en` marks the channels whose result words are captured. In lag-select with both channels active, both bits of the pair rise at the lagging event. In link mode, all six bits rise at the linked event. Otherwise each channel's bit rises with its own counted strobe.
- R11: `rd_cap` pulses for one cycle, one cycle after `rd_active` rises. While `rd_active` is high, `cap_en` stays zero and captures are held. The held captures are issued one cycle after `rd_active` is sampled low.
- R12: Every data-ready pulse is low for one cycle, one cycle after the strobe that caused it. After reset, all pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 6 | Per-channel conversion-complete strobes |
| ch_hold | input | 6 | Channel held in reset or shutdown |
| pair_sel | input | 6 | Two-bit source selector per pair |
| pair_phase | input | 24 | Signed 8-bit phase code per pair |
| link_en | input | 1 | Join all six channels into one event |
| settle_en | input | 1 | Suppress the first three strobes after start |
| idle_drive | input | 1 | Drive idle pins high instead of releasing them |
| stat_rd | input | 1 | Status register read strobe |
| rd_active | input | 1 | Host read of result words in progress |
| rdy_n | output | 3 | Active-low data-ready pins, one per pair |
| rdy_oe | output | 3 | Output enables for the data-ready pins |
| cap_en | output | 6 | First-stage result capture enables |
| rd_cap | output | 1 | Second-stage capture at read start |
| stat_n | output | 6 | Per-channel ready flags, 0 means ready |

## Verification
Every output comes from a single register stage. A strobe, hold change or read edge presented in cycle k therefore shows up on `rdy_n`, `rdy_oe`, `cap_en`, `stat_n` and `rd_cap` in cycle k+1. The one exception is the settling gate, which shifts the first visible pulse to the fourth strobe. The bench drives each cycle's stimulus just after a rising edge. It queues the expected value tagged with the cycle one edge later. A monitor then compares at the falling edge of exactly that cycle, so every check lands on the cycle its result is due. Configuration changes are made only in cycles that carry no strobe.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
  typedef enum logic [1:0] {
    SEL_LAG  = 2'b00,
    SEL_EVEN = 2'b01,
    SEL_ODD  = 2'b10,
    SEL_BOTH = 2'b11
  } sel_mode_e;

  localparam int unsigned CH_PER_PAIR = 2;
endpackage

// File: rtl/drdy_settle.sv
module drdy_settle #(
  parameter int unsigned SETTLE_N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic hold,
  input  logic settle_en,
  output logic q
);
  localparam int unsigned CW = $clog2(SETTLE_N + 1);
  localparam logic [CW-1:0] FULL = CW'(SETTLE_N);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          settled;

  always_comb begin
    settled = (cnt_q == FULL);
    cnt_d   = cnt_q;
    if (hold)
      cnt_d = '0;
    else if (strobe && !settled)
      cnt_d = cnt_q + 1'b1;
    q = strobe & ~hold & (settled | ~settle_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5: the cycle after a hold, the gate is closed again
  assert_settle_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !(q && settle_en));
endmodule

// File: rtl/drdy_pair.sv
module drdy_pair
  import drdy_pkg::*;
#(
  parameter int unsigned PH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      q,
  input  logic [1:0]      hold,
  input  logic [1:0]      mode,
  input  logic [PH_W-1:0] phase,
  input  logic            link_en,
  input  logic            link_fire,
  input  logic            idle_drive,
  output logic            pin_n,
  output logic            pin_oe,
  output logic [1:0]      lat
);
  logic odd_lags, both_on, ev;
  logic pin_n_d, pin_oe_d;

  always_comb begin
    odd_lags = phase[PH_W-1] | (phase == '0);
    both_on  = ~(hold[0] | hold[1]);
    ev       = 1'b0;
    lat      = '0;
    if (link_en) begin
      ev  = link_fire;
      lat = {2{link_fire}};
    end else begin
      case (sel_mode_e'(mode))
        SEL_LAG: begin
          if (both_on) begin
            ev  = odd_lags ? q[1] : q[0];
            lat = {2{ev}};
          end else begin
            ev  = |q;
            lat = q;
          end
        end
        SEL_EVEN: begin ev = q[0]; lat = q; end
        SEL_ODD:  begin ev = q[1]; lat = q; end
        default:  begin ev = |q;   lat = q; end
      endcase
    end
    pin_n_d  = ~ev;
    pin_oe_d = idle_drive | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_n  <= 1'b1;
      pin_oe <= 1'b0;
    end else begin
      pin_n  <= pin_n_d;
      pin_oe <= pin_oe_d;
    end
  end

  // R12: a low pin always traces back to a strobe or a linked event
  assert_pin_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_n |-> $past(link_fire || (|q)));
  // R2: even-only selection ignores the odd strobe
  assert_even_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!link_en && mode == SEL_EVEN && !q[0]) |-> pin_n);
endmodule

// File: rtl/drdy_link.sv
module drdy_link #(
  parameter int unsigned NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [NCH-1:0] q,
  input  logic [NCH-1:0] hold,
  output logic           fire
);
  logic [NCH-1:0] seen_q, seen_d, acc;

  always_comb begin
    acc    = seen_q | q;
    fire   = en & ~(|hold) & (&acc);
    seen_d = (!en || (|hold) || fire) ? '0 : acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_d;
  end
endmodule

// File: rtl/drdy_route.sv
module drdy_route
  import drdy_pkg::*;
#(
  parameter int unsigned NPAIR    = 3,
  parameter int unsigned PH_W     = 8,
  parameter int unsigned SETTLE_N = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*NPAIR-1:0]     conv_done,
  input  logic [2*NPAIR-1:0]     ch_hold,
  input  logic [2*NPAIR-1:0]     pair_sel,
  input  logic [PH_W*NPAIR-1:0]  pair_phase,
  input  logic                   link_en,
  input  logic                   settle_en,
  input  logic                   idle_drive,
  input  logic                   stat_rd,
  input  logic                   rd_active,
  output logic [NPAIR-1:0]       rdy_n,
  output logic [NPAIR-1:0]       rdy_oe,
  output logic [2*NPAIR-1:0]     cap_en,
  output logic                   rd_cap,
  output logic [2*NPAIR-1:0]     stat_n
);
  localparam int unsigned NCH = CH_PER_PAIR * NPAIR;

  logic [NCH-1:0] q, lat_ev, rdy_ev;
  logic [NCH-1:0] pend_q, pend_d, cap_d, stat_d;
  logic           fire, rd_q, rd_cap_d;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    drdy_settle #(.SETTLE_N(SETTLE_N)) u_settle (
      .clk(clk), .rst_n(rst_n), .strobe(conv_done[i]), .hold(ch_hold[i]),
      .settle_en(settle_en), .q(q[i])
    );
  end

  drdy_link #(.NCH(NCH)) u_link (
    .clk(clk), .rst_n(rst_n), .en(link_en), .q(q), .hold(ch_hold), .fire(fire)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    drdy_pair #(.PH_W(PH_W)) u_pair (
      .clk(clk), .rst_n(rst_n),
      .q(q[2*p +: 2]), .hold(ch_hold[2*p +: 2]), .mode(pair_sel[2*p +: 2]),
      .phase(pair_phase[PH_W*p +: PH_W]), .link_en(link_en), .link_fire(fire),
      .idle_drive(idle_drive), .pin_n(rdy_n[p]), .pin_oe(rdy_oe[p]),
      .lat(lat_ev[2*p +: 2])
    );
  end

  always_comb begin
    rdy_ev   = link_en ? {NCH{fire}} : q;
    stat_d   = (stat_rd ? {NCH{1'b1}} : stat_n) & ~rdy_ev;
    rd_cap_d = rd_active & ~rd_q;
    if (rd_active) begin
      cap_d  = '0;
      pend_d = pend_q | lat_ev;
    end else begin
      cap_d  = lat_ev | pend_q;
      pend_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_n <= '1;
      pend_q <= '0;
      cap_en <= '0;
      rd_q   <= 1'b0;
      rd_cap <= 1'b0;
    end else begin
      stat_n <= stat_d;
      pend_q <= pend_d;
      cap_en <= cap_d;
      rd_q   <= rd_active;
      rd_cap <= rd_cap_d;
    end
  end

  // R6: in link mode all pins carry the same level
  assert_link_same_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(link_en) |-> (rdy_n == '0 || rdy_n == '1));
  // R7: a held channel blanks every linked pulse
  assert_link_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(link_en && (|ch_hold)) |-> (&rdy_n));
  // R9: a pulsing pin is always driven
  assert_oe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (~rdy_n & ~rdy_oe) == '0);
  assert_oe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(idle_drive) |-> (&rdy_oe));
  // R11: no first-stage capture during a read
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_active) |-> (cap_en == '0));
  // R8: a flag returns to not-ready only through a status read
  for (genvar i = 0; i < NCH; i++) begin : g_stat_chk
    assert_stat_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_n[i]) |-> $past(stat_rd));
  end
endmodule

// File: tb/drdy_route_test.sv
module drdy_route_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  conv_done, ch_hold, pair_sel;
  logic [23:0] pair_phase;
  logic        link_en, settle_en, idle_drive, stat_rd, rd_active;
  logic [2:0]  rdy_n, rdy_oe;
  logic [5:0]  cap_en, stat_n;
  logic        rd_cap;

  always #2.5 clk = ~clk;

  drdy_route uut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .ch_hold(ch_hold),
    .pair_sel(pair_sel), .pair_phase(pair_phase), .link_en(link_en),
    .settle_en(settle_en), .idle_drive(idle_drive), .stat_rd(stat_rd),
    .rd_active(rd_active), .rdy_n(rdy_n), .rdy_oe(rdy_oe), .cap_en(cap_en),
    .rd_cap(rd_cap), .stat_n(stat_n)
  );

  typedef struct {
    int         due;
    int         kind;
    logic [5:0] exp;
    string      tag;
  } item_t;

  item_t sb[$];
  int    pc = 0;
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;

  always @(posedge clk) pc++;

  // monitor: compare queued expectations in the cycle they are due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == pc) begin
      item_t it;
      logic [5:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = {3'b0, rdy_n};
        1: act = {3'b0, rdy_oe};
        2: act = cap_en;
        3: act = stat_n;
        default: act = {5'b0, rd_cap};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%b expected=%b", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic tick(input logic [5:0] s, input logic srd = 1'b0, input logic ract = 1'b0);
    @(posedge clk);
    #1;
    conv_done = s;
    stat_rd   = srd;
    rd_active = ract;
  endtask

  task automatic want(input int kind, input logic [5:0] v, input string tag);
    item_t it;
    it.due  = pc + 1;
    it.kind = kind;
    it.exp  = v;
    it.tag  = tag;
    sb.push_back(it);
  endtask

  localparam int DRN = 0, OE = 1, CAP = 2, STAT = 3, RDC = 4;

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; conv_done = '0; ch_hold = '0; pair_sel = '0; pair_phase = '0;
    link_en = 1'b0; settle_en = 1'b0; idle_drive = 1'b0; stat_rd = 1'b0; rd_active = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    tick(6'b0);
    want(DRN, 6'b000111, "R12 reset pins high");
    want(OE, 6'b0, "R9 reset released");
    want(STAT, 6'b111111, "R8 reset flags");
    want(CAP, 6'b0, "R10 reset capture");

    pair_phase = {8'h00, 8'hFB, 8'h05};
    tick(6'b101001);
    want(DRN, 6'b000000, "R1 lagging strobes pass");
    want(CAP, 6'b111111, "R10 pair captured together");
    want(OE, 6'b000111, "R9 pulsing pins driven");
    want(STAT, 6'b010110, "R8 flags cleared");
    tick(6'b010110);
    want(DRN, 6'b000111, "R1 leading strobes dropped");
    want(CAP, 6'b0, "R10 no capture on leading");
    want(OE, 6'b0, "R9 idle released");
    want(STAT, 6'b0, "R8 remaining flags cleared");
    tick(6'b000100, 1'b1);
    want(STAT, 6'b111011, "R8 event wins over read");
    want(DRN, 6'b000111, "R1 negative phase odd lags");
    tick(6'b0, 1'b1);
    want(STAT, 6'b111111, "R8 read sets flags");
    tick(6'b0);

    pair_sel = 6'b011001;
    tick(6'b111111);
    want(DRN, 6'b000000, "R2 selected strobes");
    tick(6'b100110);
    want(DRN, 6'b000111, "R2 deselected strobes");
    want(CAP, 6'b100110, "R10 own strobe capture");
    tick(6'b000001);
    want(DRN, 6'b000110, "R2 even only");
    tick(6'b0);

    pair_sel = 6'b111111;
    tick(6'b000011);
    want(DRN, 6'b000110, "R3 coincident strobes");
    want(CAP, 6'b000011, "R10 both captured");
    tick(6'b0);
    want(DRN, 6'b000111, "R12 single cycle pulse");
    tick(6'b000010);
    want(DRN, 6'b000110, "R3 odd in both mode");
    tick(6'b0);

    pair_sel = 6'b0;
    ch_hold  = 6'b000001;
    tick(6'b001010);
    want(DRN, 6'b000100, "R4 active partner forwarded");
    want(CAP, 6'b001110, "R4 capture with held partner");
    tick(6'b0);
    ch_hold = 6'b0;
    idle_drive = 1'b1;
    tick(6'b0);
    want(OE, 6'b000111, "R9 idle driven");
    tick(6'b0);
    idle_drive = 1'b0;

    settle_en = 1'b1;
    pair_sel  = 6'b010000;
    ch_hold   = 6'b010000;
    tick(6'b0);
    ch_hold = 6'b0;
    tick(6'b0);
    for (int k = 0; k < 3; k++) begin
      tick(6'b010000);
      want(DRN, 6'b000111, "R5 settling strobe hidden");
      tick(6'b0);
    end
    tick(6'b010000);
    want(DRN, 6'b000011, "R5 fourth strobe shown");
    tick(6'b0);

    settle_en = 1'b0;
    link_en   = 1'b1;
    pair_sel  = 6'b010101;
    tick(6'b0, 1'b1);
    want(STAT, 6'b111111, "R8 read before link");
    tick(6'b000011);
    want(DRN, 6'b000111, "R6 waiting for all");
    want(STAT, 6'b111111, "R8 link flags wait");
    tick(6'b011100);
    want(DRN, 6'b000111, "R6 still waiting");
    tick(6'b100000);
    want(DRN, 6'b000000, "R6 linked pulse");
    want(CAP, 6'b111111, "R10 linked capture");
    want(STAT, 6'b000000, "R8 linked flags clear");
    tick(6'b0);
    want(DRN, 6'b000111, "R6 pulse ends");

    tick(6'b0, 1'b1);
    ch_hold = 6'b001000;
    tick(6'b0);
    tick(6'b111111);
    want(DRN, 6'b000111, "R7 held channel blanks link");
    want(STAT, 6'b111111, "R7 flags unchanged");
    tick(6'b110111);
    want(DRN, 6'b000111, "R7 still blanked");
    tick(6'b0);
    ch_hold = 6'b0;
    tick(6'b0);
    link_en  = 1'b0;
    pair_sel = 6'b111111;
    tick(6'b0);

    tick(6'b0, 1'b0, 1'b1);
    want(RDC, 6'b000001, "R11 read start capture");
    want(CAP, 6'b0, "R11 no first stage");
    tick(6'b000001, 1'b0, 1'b1);
    want(RDC, 6'b0, "R11 read capture one cycle");
    want(CAP, 6'b0, "R11 capture held");
    want(DRN, 6'b000110, "R11 pin still pulses");
    tick(6'b0);
    want(CAP, 6'b000001, "R11 held capture released");
    tick(6'b0);
    want(CAP, 6'b0, "R11 release single cycle");
    tick(6'b0);
    tick(6'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule